// File: doc/BRIEF.md
# Linked-Pair Buffered PWM Generator

This block turns two output-compare channels into one PWM output with double buffering. Both channels share one up-counter. The counter runs from zero to a programmable modulo and then wraps. Each channel has its own 16-bit compare value. A pin is driven high when the counter wraps and driven low when the counter matches the compare value. The pin is never toggled, so a zero compare value gives a 0% duty cycle and every period starts again from a known level.

When the link bit is set in the first channel's control register, the two compare values take turns controlling the first pin. Software writes the next width into whichever set is not in use. At each wrap, control passes to the set whose low byte was written last. The second pin is then released for general-purpose use, and the second channel's control register is ignored. When the link bit is cleared, both channels go back to independent operation at the next wrap.

Top module: `lpwm_pair`

## Requirements
- R1: After reset the count is 0 and both pins are low. The count steps by one each clock up to the modulo. `ovf_o` is high for the one clock in which the count is at or above the modulo, and the next count is 0.
- R2: A pin that is enabled at a wrap is high while the count is below the compare value of the set that controls it. A compare value of 0 keeps it low for the whole period. A value above the modulo keeps it high for the whole period. A pin only rises in the first cycle of a period.
- R3: Bit 0 of the first control register (address 0) is the link bit. It takes effect at the next wrap. While it is in effect, `gpio_rel_o` is high and `pin_b_o` is low.
- R4: In the first period after linking takes effect, compare set A (addresses 1 and 2) controls `pwm_o`.
- R5: A write to the low byte of set B (address 5) while set A is in control does not change the current period. Set B controls from the next period onwards.
- R6: At every wrap while linked, control goes to the set whose low byte was written most recently. A low-byte write in the wrap cycle itself counts for that wrap.
- R7: Writing the high byte of a set (address 1 or 4) blocks compare matches on that set until its low byte (address 2 or 5) is written. During the block, a pin that was set stays high through the old compare point.
- R8: While the link bit is set, writes to the second control register (address 3) are discarded. This is visible after unlinking, because `pin_b_o` keeps its previous enable.
- R9: After the link bit is cleared, `gpio_rel_o` stays high until the next wrap. From that wrap onwards, both pins run independently from their own sets.
- R10: Bit 1 of each control register enables its pin. The bit is sampled at the wrap, and a pin that is disabled at the wrap stays low for the whole period. The modulo is written at addresses 6 (high byte) and 7 (low byte).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0..7) |
| wr_data | input | 8 | Register write byte |
| cnt_o | output | W | Shared counter value |
| ovf_o | output | 1 | Wrap strobe |
| pwm_o | output | 1 | First pin; carries the buffered output when linked |
| pin_b_o | output | 1 | Second pin (independent mode only) |
| gpio_rel_o | output | 1 | Second pin released to general-purpose use |

## Verification
The case that needs most care is a compare-set write landing in the same cycle as a wrap. The wrap decides which set controls the next period, and the write changes which set was written last. The bench asserts a low-byte write of set A exactly in the cycle where `ovf_o` is high. It then checks that the period which starts on that edge already uses the new set and its new width. A behavioural model is compared with `cnt_o`, `ovf_o`, `pwm_o`, `pin_b_o` and `gpio_rel_o` on every clock, so a race between a wrap and a compare match on the same count value is also judged.

// File: rtl/lpwm_pair.sv
module lpwm_pair #(
  parameter int W = 16,
  parameter logic [W-1:0] RST_MOD = W'(255)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [2:0]   wr_addr,
  input  logic [7:0]   wr_data,
  output logic [W-1:0] cnt_o,
  output logic         ovf_o,
  output logic         pwm_o,
  output logic         pin_b_o,
  output logic         gpio_rel_o
);
  logic [W-1:0] cnt, modv, cmp_a, cmp_b, cmp_cur;
  logic blk_a, blk_b, blk_cur, link_reg, link_act, en_a, en_b;
  logic sel_b, last_b, last_nxt, q_a, q_b, hit_a, hit_b, ovf;
  logic wa_hi, wa_lo, wb_hi, wb_lo;

  assign wa_hi = wr_en && wr_addr == 3'd1;
  assign wa_lo = wr_en && wr_addr == 3'd2;
  assign wb_hi = wr_en && wr_addr == 3'd4;
  assign wb_lo = wr_en && wr_addr == 3'd5;

  assign ovf      = cnt >= modv;
  assign last_nxt = wb_lo ? 1'b1 : (wa_lo ? 1'b0 : last_b);
  assign cmp_cur  = (link_act && sel_b) ? cmp_b : cmp_a;
  assign blk_cur  = (link_act && sel_b) ? blk_b : blk_a;
  assign hit_a    = cnt == cmp_cur && !blk_cur;
  assign hit_b    = cnt == cmp_b && !blk_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      modv <= RST_MOD;
      cmp_a <= '0;
      cmp_b <= '0;
      blk_a <= 1'b0;
      blk_b <= 1'b0;
      link_reg <= 1'b0;
      link_act <= 1'b0;
      en_a <= 1'b0;
      en_b <= 1'b0;
      sel_b <= 1'b0;
      last_b <= 1'b0;
      q_a <= 1'b0;
      q_b <= 1'b0;
    end else begin
      cnt <= ovf ? '0 : cnt + 1'b1;
      if (wr_en) begin
        case (wr_addr)
          3'd0: begin link_reg <= wr_data[0]; en_a <= wr_data[1]; end
          3'd1: cmp_a[W-1:8] <= wr_data[W-9:0];
          3'd2: cmp_a[7:0] <= wr_data;
          3'd3: if (!link_reg) en_b <= wr_data[1];
          3'd4: cmp_b[W-1:8] <= wr_data[W-9:0];
          3'd5: cmp_b[7:0] <= wr_data;
          3'd6: modv[W-1:8] <= wr_data[W-9:0];
          default: modv[7:0] <= wr_data;
        endcase
      end
      if (wa_hi) blk_a <= 1'b1;
      else if (wa_lo) blk_a <= 1'b0;
      if (wb_hi) blk_b <= 1'b1;
      else if (wb_lo) blk_b <= 1'b0;
      if (wb_lo || wa_lo) last_b <= last_nxt;
      else if (ovf && link_reg && !link_act) last_b <= 1'b0;
      if (ovf) begin
        link_act <= link_reg;
        sel_b <= link_reg && link_act && last_nxt;
        q_a <= en_a;
        q_b <= en_b && !link_reg;
      end else begin
        if (hit_a) q_a <= 1'b0;
        if (hit_b) q_b <= 1'b0;
      end
    end
  end

  assign cnt_o      = cnt;
  assign ovf_o      = ovf;
  assign pwm_o      = q_a && !hit_a;
  assign pin_b_o    = !link_act && q_b && !hit_b;
  assign gpio_rel_o = link_act;
endmodule

// File: rtl/lpwm_pair_chk.sv
module lpwm_pair_chk #(parameter int W = 16) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] cnt,
  input logic         ovf,
  input logic         pwm,
  input logic         pin_b,
  input logic         gpio
);
  assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n) ovf |=> cnt == '0);
  assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n) !ovf |=> cnt == $past(cnt) + W'(1));
  assert_pin_released_R3: assert property (@(posedge clk) disable iff (!rst_n) gpio |-> !pin_b);
  assert_link_at_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n) !ovf |=> $stable(gpio));
  assert_rise_start_R2: assert property (@(posedge clk) disable iff (!rst_n) $rose(pwm) |-> cnt == '0);
  assert_rise_b_start_R2: assert property (@(posedge clk) disable iff (!rst_n) $rose(pin_b) |-> cnt == '0);
endmodule

bind lpwm_pair lpwm_pair_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt_o), .ovf(ovf_o),
  .pwm(pwm_o), .pin_b(pin_b_o), .gpio(gpio_rel_o)
);

// File: tb/lpwm_pair_test.sv
`timescale 1ns/1ps
module lpwm_pair_test;
  localparam int W = 16;
  localparam int MODV = 9;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [W-1:0] cnt_o;
  logic ovf_o, pwm_o, pin_b_o, gpio_rel_o;
  int total = 0, bad = 0, h = 0;

  lpwm_pair #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cnt_o(cnt_o), .ovf_o(ovf_o), .pwm_o(pwm_o), .pin_b_o(pin_b_o), .gpio_rel_o(gpio_rel_o)
  );

  always #4 clk = ~clk;

  // behavioural reference
  int m_cnt, m_mod, m_ca, m_cb;
  bit m_ba, m_bb, m_lreg, m_link, m_ena, m_enb, m_sel, m_last, m_qa, m_qb;

  function automatic int cur_cmp();
    return (m_link && m_sel) ? m_cb : m_ca;
  endfunction
  function automatic bit cur_hit();
    bit blk = (m_link && m_sel) ? m_bb : m_ba;
    return m_cnt == cur_cmp() && !blk;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_mod = 255; m_ca = 0; m_cb = 0; m_ba = 0; m_bb = 0;
      m_lreg = 0; m_link = 0; m_ena = 0; m_enb = 0; m_sel = 0; m_last = 0; m_qa = 0; m_qb = 0;
    end else begin
      bit ov, ha, hb, lastn, wlo;
      ov = m_cnt >= m_mod;
      ha = cur_hit();
      hb = (m_cnt == m_cb) && !m_bb;
      wlo = wr_en && (wr_addr == 2 || wr_addr == 5);
      lastn = wlo ? (wr_addr == 5) : m_last;
      if (ov) begin
        m_sel = m_lreg && m_link && lastn;
        m_qa = m_ena;
        m_qb = m_enb && !m_lreg;
      end else begin
        if (ha) m_qa = 0;
        if (hb) m_qb = 0;
      end
      if (wlo) m_last = lastn;
      else if (ov && m_lreg && !m_link) m_last = 0;
      if (ov) m_link = m_lreg;
      m_cnt = ov ? 0 : m_cnt + 1;
      if (wr_en) begin
        case (wr_addr)
          0: begin m_lreg = wr_data[0]; m_ena = wr_data[1]; end
          1: begin m_ca = (m_ca % 256) + 256 * wr_data; m_ba = 1; end
          2: begin m_ca = (m_ca / 256) * 256 + wr_data; m_ba = 0; end
          3: if (!m_lreg) m_enb = wr_data[1];
          4: begin m_cb = (m_cb % 256) + 256 * wr_data; m_bb = 1; end
          5: begin m_cb = (m_cb / 256) * 256 + wr_data; m_bb = 0; end
          6: m_mod = (m_mod % 256) + 256 * wr_data;
          default: m_mod = (m_mod / 256) * 256 + wr_data;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R1 model cnt", cnt_o, m_cnt);
    chk("R1 model ovf", ovf_o, m_cnt >= m_mod);
    chk("R2 model pwm", pwm_o, m_qa && !cur_hit());
    chk("R8 model pin_b", pin_b_o, !m_link && m_qb && !((m_cnt == m_cb) && !m_bb));
    chk("R3 model gpio", gpio_rel_o, m_link);
  end

  task automatic wr(input int a, input int d);
    @(negedge clk); wr_en = 1; wr_addr = 3'(a); wr_data = 8'(d);
    @(negedge clk); wr_en = 0;
  endtask
  task automatic wait_ovf();
    do @(negedge clk); while (!ovf_o);
  endtask
  task automatic count_a();
    h = 0;
    for (int i = 0; i <= MODV; i++) begin @(negedge clk); if (pwm_o) h++; end
  endtask
  task automatic count_b();
    h = 0;
    for (int i = 0; i <= MODV; i++) begin @(negedge clk); if (pin_b_o) h++; end
  endtask

  initial begin
    #100000;
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset cnt", cnt_o, 1);
    chk("R1 reset pwm", pwm_o, 0);
    chk("R1 reset pin_b", pin_b_o, 0);
    wr(6, 0); wr(7, MODV);
    wr(1, 0); wr(2, 4); wr(0, 2);
    wait_ovf(); wait_ovf(); count_a(); chk("R2 width 4", h, 4);
    wr(2, 0); wait_ovf(); count_a(); chk("R2 zero duty", h, 0);
    wr(2, 20); wait_ovf(); count_a(); chk("R2 full duty", h, MODV + 1);
    wr(4, 0); wr(5, 7); wr(3, 2);
    wait_ovf(); count_b(); chk("R2 pin_b width 7", h, 7);
    wr(0, 0); wait_ovf(); count_a(); chk("R10 disabled low", h, 0);
    wr(0, 2); wr(2, 3); wr(1, 0);
    wait_ovf(); count_a(); chk("R7 blocked stays high", h, MODV + 1);
    wr(2, 3); wait_ovf(); count_a(); chk("R7 unblocked width 3", h, 3);
    wait_ovf(); wr(0, 3);
    chk("R3 link waits for wrap", gpio_rel_o, 0);
    wait_ovf(); count_a(); chk("R4 set A after link", h, 3);
    chk("R3 gpio released", gpio_rel_o, 1);
    fork count_b(); join chk("R3 pin_b low", h, 0);
    wait_ovf();
    fork count_a(); begin wr(4, 0); wr(5, 6); end join
    chk("R5 current period unchanged", h, 3);
    count_a(); chk("R5 set B next period", h, 6);
    fork count_a(); wr(2, 2); join chk("R6 B still controls", h, 6);
    count_a(); chk("R6 back to A", h, 2);
    fork count_a(); wr(5, 5); join chk("R6 A still controls", h, 2);
    count_a(); chk("R6 back to B", h, 5);
    wait_ovf();
    while (!ovf_o) @(negedge clk);
    do @(negedge clk); while (!ovf_o);
    wr_en = 1; wr_addr = 3'd2; wr_data = 8'd8;
    fork count_a(); begin @(negedge clk); wr_en = 0; end join
    chk("R6 write in wrap cycle", h, 8);
    wr(3, 0);
    wait_ovf(); wr(0, 2);
    chk("R9 gpio held until wrap", gpio_rel_o, 1);
    wait_ovf(); @(negedge clk);
    chk("R9 gpio returned", gpio_rel_o, 0);
    wait_ovf(); count_b(); chk("R8 ctl B write ignored", h, 5);
    wait_ovf(); count_a(); chk("R9 A independent", h, 8);
    wr(0, 0); wait_ovf(); count_a(); chk("R10 enable sampled at wrap", h, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule